// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recently used virtual-to-physical page mappings and answers translation queries in the same cycle they are asked. A requester presents a 20-bit virtual page number, the 12-bit offset within the page and an access kind (load, store or instruction fetch). Combinational logic compares the page number against the tag of every valid slot and reports a hit, a miss or a permission fault. On a hit it also returns the physical page number, the full physical address and the permission bits of the slot.

A miss tells the requester that a page-table walk is needed. The walker sits outside this block and writes its result through the refill port, so that a retried access hits. The buffer never changes a slot on its own behalf. Slots change only through refill, through a per-page invalidate, and through a whole-array flush that happens whenever the page-table base value presented to the block differs from the value seen on the previous clock. A store to a writable page whose dirty bit is still clear is reported as a miss. The walker then sets the dirty bit in memory and refills the slot.

Top module: `tlb_fa`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so every lookup misses until a refill is made.
- R2: A lookup that matches a valid slot with sufficient permission raises `lk_hit` in the same cycle. It drives `lk_ppn` with the stored physical page, `lk_paddr` with that page concatenated above `lk_off`, and `lk_perm` with the stored bits ([3]=read, [2]=write, [1]=execute, [0]=dirty).
- R3: A lookup with no matching valid slot raises `lk_miss` only. A refill applied on a clock edge makes a lookup of that page hit from the next cycle on.
- R4: The access code on `lk_acc` is 0 for load, 1 for store and 2 for fetch, and 3 is treated as a load. A load needs the read bit, a store the write bit and a fetch the execute bit. A matching slot without the needed bit raises `lk_fault` only, and `lk_ppn`, `lk_paddr` and `lk_perm` read zero. At most one of hit, miss and fault is high.
- R5: A store that matches a writable slot whose dirty bit is clear raises `lk_miss`. After a refill with the dirty bit set, the same store hits.
- R6: When `ptb_base` differs from its value on the previous clock, every slot is invalid from the next cycle on.
- R7: An invalidate request clears only the slot whose tag equals `inv_vpn`. All other slots keep hitting.
- R8: When a flush and a refill fall on the same clock edge, the flush wins and the refilled page misses afterwards.
- R9: Lookups never modify slot contents. A store that misses on a clean slot leaves it clean, so the store misses again.
- R10: Refilling a page that is already present overwrites that slot in place, so no page is ever held twice and no other slot is displaced.
- R11: A refill of a new page takes the lowest-numbered invalid slot while one exists.
- R12: When all slots are valid, a refill of a new page replaces the slot chosen by a binary-tree pseudo-LRU. Each tree node points to the half to replace next. A hit or a refill of slot i turns every node on the path to i toward the other half.
- R13: While `lk_valid` is low, `lk_hit`, `lk_miss`, `lk_fault`, `lk_ppn`, `lk_paddr` and `lk_perm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ptb_base | input | 32 | Current page-table base value; any change flushes |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Byte offset within the page |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lk_hit | output | 1 | Translation found with sufficient permission |
| lk_miss | output | 1 | Walk needed (absent page, or store to clean page) |
| lk_fault | output | 1 | Page present but access not permitted |
| lk_ppn | output | 20 | Physical page number on a hit, else zero |
| lk_paddr | output | 32 | Physical address on a hit, else zero |
| lk_perm | output | 4 | Slot permission bits on a hit, else zero |
| fill_valid | input | 1 | Refill request present |
| fill_vpn | input | 20 | Virtual page being installed |
| fill_ppn | input | 20 | Physical page being installed |
| fill_perm | input | 4 | Permission bits being installed, same layout as lk_perm |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
A corrupted tag, page number or permission field reaches the ports on the first lookup of that page: the wrong physical address, a false fault or a false miss appears in that very cycle. A slot left valid after a flush or an invalidate shows up as a stale hit on the next lookup of the old page. A fault in the replacement tree stays hidden until the array is full. It shows only on the lookup sweep after the next refill of a new page, when the wrong page has gone missing. The bench therefore compares every output against a behavioural model on every clock, and it sweeps all resident pages after each forced eviction.

// File: rtl/tlb_pkg.sv
// Package: shared encodings for the translation buffer.
// Assumes the permission vector layout [3]=read [2]=write [1]=execute [0]=dirty.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int PERM_W = 4;
    localparam int P_RD   = 3;
    localparam int P_WR   = 2;
    localparam int P_EX   = 1;
    localparam int P_DY   = 0;
endpackage

// File: rtl/tlb_entry_array.sv
// Storage for ENTRIES translation slots with parallel tag compare.
// Does: holds valid/tag/ppn/perm per slot, compares the lookup page and the
// refill page against every slot, applies flush > write > invalidate.
// Assumes: at most one valid slot matches any page (the top keeps this).
module tlb_entry_array #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int PERM_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic [VPN_W-1:0]           fill_vpn,
    input  logic                       flush,
    input  logic                       inv_valid,
    input  logic [VPN_W-1:0]           inv_vpn,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [PPN_W-1:0]           wr_ppn,
    input  logic [PERM_W-1:0]          wr_perm,
    output logic [ENTRIES-1:0]         lk_match,
    output logic [ENTRIES-1:0]         fill_match,
    output logic [ENTRIES-1:0]         valid_vec,
    output logic [PPN_W-1:0]           rd_ppn,
    output logic [PERM_W-1:0]          rd_perm
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]  tag_q  [ENTRIES];
    logic [PPN_W-1:0]  ppn_q  [ENTRIES];
    logic [PERM_W-1:0] perm_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        // Purpose: valid bit, flush first, then refill, then invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_vec[i] <= 1'b0;
            else if (flush)
                valid_vec[i] <= 1'b0;
            else if (sel)
                valid_vec[i] <= 1'b1;
            else if (inv_valid && (tag_q[i] == inv_vpn))
                valid_vec[i] <= 1'b0;
        end

        // Purpose: payload capture on refill; not reset, guarded by valid.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[i]  <= fill_vpn;
                ppn_q[i]  <= wr_ppn;
                perm_q[i] <= wr_perm;
            end
        end

        assign lk_match[i]   = valid_vec[i] && (tag_q[i] == lk_vpn);
        assign fill_match[i] = valid_vec[i] && (tag_q[i] == fill_vpn);
    end

    // Purpose: OR-mux of the single matching slot's payload.
    always_comb begin
        rd_ppn  = '0;
        rd_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                rd_ppn  = rd_ppn | ppn_q[i];
                rd_perm = rd_perm | perm_q[i];
            end
        end
    end
endmodule

// File: rtl/tlb_plru.sv
// Binary-tree pseudo-LRU replacement state.
// Does: keeps ENTRIES-1 node bits (heap order, node n has children 2n+1 and
// 2n+2); each bit names the half to replace next (0 left, 1 right). Two touch
// ports are applied in order a then b on each edge.
// Assumes: ENTRIES is a power of two, at least 2.
module tlb_plru #(
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       touch_a_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_a_idx,
    input  logic                       touch_b_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_b_idx,
    output logic [$clog2(ENTRIES)-1:0] victim_idx
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int NODES = ENTRIES - 1;

    logic [NODES-1:0] tree_q, tree_nxt;

    function automatic logic [NODES-1:0] touch_path(input logic [NODES-1:0] t,
                                                    input logic [IDX_W-1:0] idx);
        logic [NODES-1:0] r;
        int node;
        r    = t;
        node = 0;
        for (int l = 0; l < IDX_W; l++) begin
            r[node] = ~idx[IDX_W-1-l];
            node    = 2 * node + 1 + int'(idx[IDX_W-1-l]);
        end
        return r;
    endfunction

    // Purpose: next tree state from the two ordered touches.
    always_comb begin
        tree_nxt = tree_q;
        if (touch_a_en) tree_nxt = touch_path(tree_nxt, touch_a_idx);
        if (touch_b_en) tree_nxt = touch_path(tree_nxt, touch_b_idx);
    end

    // Purpose: follow node pointers from the root to a leaf.
    always_comb begin
        int node;
        node       = 0;
        victim_idx = '0;
        for (int l = 0; l < IDX_W; l++) begin
            victim_idx[IDX_W-1-l] = tree_q[node];
            node = 2 * node + 1 + int'(tree_q[node]);
        end
    end

    // Purpose: tree state register.
    always_ff @(posedge clk) begin
        if (!rst_n) tree_q <= '0;
        else        tree_q <= tree_nxt;
    end
endmodule

// File: rtl/tlb_perm_check.sv
// Outcome classifier for a lookup.
// Does: turns request, match and stored permissions into exactly one of
// hit / miss / fault (or none when idle).
// Assumes: permission layout from tlb_pkg.
module tlb_perm_check
    import tlb_pkg::*;
#(
    parameter int PW = PERM_W
) (
    input  logic          req_valid,
    input  logic [1:0]    acc,
    input  logic          any_match,
    input  logic [PW-1:0] perm,
    output logic          hit,
    output logic          miss,
    output logic          fault
);
    logic need_ok;
    logic clean_store;

    // Purpose: pick the permission bit the access kind needs.
    always_comb begin
        unique case (acc_e'(acc))
            ACC_STORE: need_ok = perm[P_WR];
            ACC_FETCH: need_ok = perm[P_EX];
            default:   need_ok = perm[P_RD];
        endcase
    end

    assign clean_store = (acc_e'(acc) == ACC_STORE) && !perm[P_DY];

    // Purpose: exclusive outcome decode.
    always_comb begin
        hit   = 1'b0;
        miss  = 1'b0;
        fault = 1'b0;
        if (req_valid) begin
            if (!any_match)       miss  = 1'b1;
            else if (!need_ok)    fault = 1'b1;
            else if (clean_store) miss  = 1'b1;
            else                  hit   = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_fa.sv
// Fully associative translation buffer, top level.
// Does: same-cycle lookup, refill placement (existing slot, else lowest free,
// else pseudo-LRU), per-page invalidate, flush on any change of ptb_base.
// Assumes: refills come from an external walker; lookups never write slots.
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    parameter int BASE_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BASE_W-1:0]     ptb_base,
    input  logic                  lk_valid,
    input  logic [VPN_W-1:0]      lk_vpn,
    input  logic [OFF_W-1:0]      lk_off,
    input  logic [1:0]            lk_acc,
    output logic                  lk_hit,
    output logic                  lk_miss,
    output logic                  lk_fault,
    output logic [PPN_W-1:0]      lk_ppn,
    output logic [PPN_W+OFF_W-1:0] lk_paddr,
    output logic [PERM_W-1:0]     lk_perm,
    input  logic                  fill_valid,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [PPN_W-1:0]      fill_ppn,
    input  logic [PERM_W-1:0]     fill_perm,
    input  logic                  inv_valid,
    input  logic [VPN_W-1:0]      inv_vpn
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [BASE_W-1:0]  base_q;
    logic               flush;
    logic [ENTRIES-1:0] lk_match, fill_match, valid_vec;
    logic [PPN_W-1:0]   rd_ppn;
    logic [PERM_W-1:0]  rd_perm;
    logic [IDX_W-1:0]   lk_idx, fill_hit_idx, free_idx, plru_idx, wr_idx;
    logic               free_any;

    // Purpose: remember the last base value so a change can be seen.
    always_ff @(posedge clk) begin
        base_q <= ptb_base;
    end

    assign flush = rst_n && (ptb_base != base_q);

    tlb_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
    ) i_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (lk_vpn),
        .fill_vpn   (fill_vpn),
        .flush      (flush),
        .inv_valid  (inv_valid),
        .inv_vpn    (inv_vpn),
        .wr_en      (fill_valid),
        .wr_idx     (wr_idx),
        .wr_ppn     (fill_ppn),
        .wr_perm    (fill_perm),
        .lk_match   (lk_match),
        .fill_match (fill_match),
        .valid_vec  (valid_vec),
        .rd_ppn     (rd_ppn),
        .rd_perm    (rd_perm)
    );

    // Purpose: one-hot to index for lookup match and refill match.
    always_comb begin
        lk_idx       = '0;
        fill_hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i])   lk_idx       = lk_idx | IDX_W'(i);
            if (fill_match[i]) fill_hit_idx = fill_hit_idx | IDX_W'(i);
        end
    end

    // Purpose: lowest-numbered invalid slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Purpose: refill placement priority.
    always_comb begin
        if (|fill_match)   wr_idx = fill_hit_idx;
        else if (free_any) wr_idx = free_idx;
        else               wr_idx = plru_idx;
    end

    tlb_plru #(.ENTRIES(ENTRIES)) i_plru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_a_en  (lk_hit),
        .touch_a_idx (lk_idx),
        .touch_b_en  (fill_valid),
        .touch_b_idx (wr_idx),
        .victim_idx  (plru_idx)
    );

    tlb_perm_check #(.PW(PERM_W)) i_check (
        .req_valid (lk_valid),
        .acc       (lk_acc),
        .any_match (|lk_match),
        .perm      (rd_perm),
        .hit       (lk_hit),
        .miss      (lk_miss),
        .fault     (lk_fault)
    );

    assign lk_ppn   = lk_hit ? rd_ppn : '0;
    assign lk_paddr = lk_hit ? {rd_ppn, lk_off} : '0;
    assign lk_perm  = lk_hit ? rd_perm : '0;
endmodule

// File: rtl/tlb_fa_chk.sv
// Checker for tlb_fa, attached by bind. Observes ports only.
module tlb_fa_chk #(
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 20,
    parameter int BASE_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [BASE_W-1:0]      ptb_base,
    input logic                   lk_valid,
    input logic [OFF_W-1:0]       lk_off,
    input logic [1:0]             lk_acc,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic                   lk_fault,
    input logic [PPN_W-1:0]       lk_ppn,
    input logic [PPN_W+OFF_W-1:0] lk_paddr,
    input logic [3:0]             lk_perm
);
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lk_hit, lk_miss, lk_fault}) <= 1);

    assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_paddr == '0 && lk_ppn == '0 && lk_perm == '0));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault) && lk_paddr == '0);

    assert_paddr_join_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr == {lk_ppn, lk_off}));

    assert_store_needs_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_acc == 2'd1) |-> (lk_perm[2] && lk_perm[0]));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptb_base != $past(ptb_base)) |=> !(lk_hit || lk_fault));
endmodule

bind tlb_fa tlb_fa_chk #(.OFF_W(OFF_W), .PPN_W(PPN_W), .BASE_W(BASE_W)) i_tlb_fa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptb_base (ptb_base),
    .lk_valid (lk_valid),
    .lk_off   (lk_off),
    .lk_acc   (lk_acc),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault),
    .lk_ppn   (lk_ppn),
    .lk_paddr (lk_paddr),
    .lk_perm  (lk_perm)
);

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ptb_base;
    logic        lk_valid;
    logic [19:0] lk_vpn;
    logic [11:0] lk_off;
    logic [1:0]  lk_acc;
    logic        lk_hit, lk_miss, lk_fault;
    logic [19:0] lk_ppn;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_perm;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_ppn;
    logic [3:0]  fill_perm;
    logic        inv_valid;
    logic [19:0] inv_vpn;

    // staged stimulus, applied at the falling edge
    logic        s_rst = 1'b0;
    logic [31:0] s_base = '0;
    logic        s_lkv = 1'b0;
    logic [19:0] s_vpn = '0;
    logic [11:0] s_off = '0;
    logic [1:0]  s_acc = '0;
    logic        s_fv = 1'b0;
    logic [19:0] s_fvpn = '0, s_fppn = '0;
    logic [3:0]  s_fperm = '0;
    logic        s_iv = 1'b0;
    logic [19:0] s_ivpn = '0;

    int    vectors = 0;
    int    miscompares = 0;
    string phase = "R1 reset";

    // reference model state
    bit         m_v [N];
    bit [19:0]  m_tag [N];
    bit [19:0]  m_ppn [N];
    bit [3:0]   m_perm [N];
    bit [14:0]  m_tree;
    bit [31:0]  m_base;

    bit        e_hit, e_miss, e_fault;
    bit [19:0] e_ppn;
    bit [31:0] e_paddr;
    bit [3:0]  e_perm;
    int        e_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa i_tlb_fa (
        .clk(clk), .rst_n(rst_n), .ptb_base(ptb_base),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_ppn(lk_ppn), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    function automatic bit [14:0] tree_touch(bit [14:0] t, int idx);
        int node = 0;
        for (int l = 3; l >= 0; l--) begin
            int b = (idx >> l) & 1;
            t[node] = (b == 0);
            node = 2 * node + 1 + b;
        end
        return t;
    endfunction

    function automatic int tree_victim();
        int node = 0;
        int idx = 0;
        for (int l = 0; l < 4; l++) begin
            int b = int'(m_tree[node]);
            idx = idx * 2 + b;
            node = 2 * node + 1 + b;
        end
        return idx;
    endfunction

    // expected outputs from model state and applied inputs
    task automatic model_eval();
        e_hit = 0; e_miss = 0; e_fault = 0; e_ppn = 0; e_paddr = 0; e_perm = 0; e_idx = -1;
        if (lk_valid) begin
            for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == lk_vpn) e_idx = i;
            if (e_idx < 0) e_miss = 1;
            else begin
                bit [3:0] p = m_perm[e_idx];
                bit ok = (lk_acc == 2'd1) ? p[2] : (lk_acc == 2'd2) ? p[1] : p[3];
                if (!ok) e_fault = 1;
                else if (lk_acc == 2'd1 && !p[0]) e_miss = 1;
                else begin
                    e_hit = 1; e_ppn = m_ppn[e_idx];
                    e_paddr = {m_ppn[e_idx], lk_off}; e_perm = p;
                end
            end
        end
    endtask

    task automatic model_update();
        int tgt = -1;
        bit flush;
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_tree = 0;
            m_base = ptb_base;
            return;
        end
        flush = (ptb_base != m_base);
        if (fill_valid) begin
            for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == fill_vpn) tgt = i;
            if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) tgt = i;
            if (tgt < 0) tgt = tree_victim();
        end
        if (e_hit) m_tree = tree_touch(m_tree, e_idx);
        if (fill_valid) m_tree = tree_touch(m_tree, tgt);
        if (inv_valid) for (int i = 0; i < N; i++) if (m_tag[i] == inv_vpn) m_v[i] = 0;
        if (fill_valid) begin
            m_v[tgt] = 1; m_tag[tgt] = fill_vpn; m_ppn[tgt] = fill_ppn; m_perm[tgt] = fill_perm;
        end
        if (flush) foreach (m_v[i]) m_v[i] = 0;
        m_base = ptb_base;
    endtask

    task automatic step();
        @(negedge clk);
        rst_n = s_rst; ptb_base = s_base;
        lk_valid = s_lkv; lk_vpn = s_vpn; lk_off = s_off; lk_acc = s_acc;
        fill_valid = s_fv; fill_vpn = s_fvpn; fill_ppn = s_fppn; fill_perm = s_fperm;
        inv_valid = s_iv; inv_vpn = s_ivpn;
        #(CLK_PERIOD/4);
        model_eval();
        vectors++;
        if ({lk_hit, lk_miss, lk_fault} !== {e_hit, e_miss, e_fault} || lk_ppn !== e_ppn ||
            lk_paddr !== e_paddr || lk_perm !== e_perm) begin
            miscompares++;
            $display("FAIL %s: actual hmf=%b%b%b ppn=%h pa=%h perm=%b expected hmf=%b%b%b ppn=%h pa=%h perm=%b",
                     phase, lk_hit, lk_miss, lk_fault, lk_ppn, lk_paddr, lk_perm,
                     e_hit, e_miss, e_fault, e_ppn, e_paddr, e_perm);
        end
        @(posedge clk);
        model_update();
    endtask

    task automatic idle();
        s_lkv = 0; s_fv = 0; s_iv = 0;
    endtask

    task automatic look(input bit [19:0] v, input bit [1:0] a, input bit [11:0] o);
        idle(); s_lkv = 1; s_vpn = v; s_acc = a; s_off = o; step();
    endtask

    task automatic fill(input bit [19:0] v, input bit [19:0] p, input bit [3:0] pm);
        idle(); s_fv = 1; s_fvpn = v; s_fppn = p; s_fperm = pm; step();
    endtask

    initial begin
        s_rst = 0;
        repeat (3) step();
        s_rst = 1;
        phase = "R1 lookup after reset misses";
        look(20'h00042, 2'd0, 12'h111);
        look(20'h00000, 2'd2, 12'h000);

        phase = "R3 refill then hit";
        fill(20'h00042, 20'hABCDE, 4'b1100);
        phase = "R2 hit returns ppn and address";
        look(20'h00042, 2'd0, 12'h44C);
        look(20'h00042, 2'd3, 12'hFFF);
        phase = "R4 fetch without execute faults";
        look(20'h00042, 2'd2, 12'h123);
        phase = "R5 R9 store to clean page misses, stays clean";
        look(20'h00042, 2'd1, 12'h010);
        look(20'h00042, 2'd1, 12'h010);
        phase = "R5 store hits after dirty refill";
        fill(20'h00042, 20'hABCDE, 4'b1101);
        look(20'h00042, 2'd1, 12'h020);
        phase = "R4 store without write faults";
        fill(20'h00050, 20'h01234, 4'b1011);
        look(20'h00050, 2'd1, 12'h000);
        look(20'h00050, 2'd2, 12'h004);

        phase = "R6 base change flushes";
        s_base = 32'h1000_5000; idle(); step();
        look(20'h00042, 2'd0, 12'h0);
        look(20'h00050, 2'd2, 12'h0);

        phase = "R11 fill sixteen pages into free slots";
        for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h20000 + 20'(i), 4'b1111);
        for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), 2'd0, 12'(i));

        phase = "R12 pseudo-LRU victim on full array";
        look(20'h00103, 2'd1, 12'h0);
        look(20'h0010B, 2'd2, 12'h0);
        fill(20'h00200, 20'h30000, 4'b1110);
        look(20'h00200, 2'd0, 12'h0);
        for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), 2'd0, 12'h0);
        fill(20'h00201, 20'h30001, 4'b1110);
        for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), 2'd0, 12'h0);

        phase = "R10 refill of present page overwrites in place";
        fill(20'h00105, 20'h7FFFF, 4'b1111);
        look(20'h00105, 2'd0, 12'h321);
        for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), 2'd0, 12'h0);
        look(20'h00200, 2'd0, 12'h0);
        look(20'h00201, 2'd0, 12'h0);

        phase = "R7 invalidate clears only one page";
        idle(); s_iv = 1; s_ivpn = 20'h00108; step();
        for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), 2'd0, 12'h0);

        phase = "R13 idle lookup outputs zero";
        idle(); s_vpn = 20'h00101; s_acc = 2'd0; step();

        phase = "R8 flush beats same-edge refill";
        idle(); s_base = 32'h2000_0000; s_fv = 1; s_fvpn = 20'h00777; s_fppn = 20'h11111;
        s_fperm = 4'b1111; step();
        look(20'h00777, 2'd0, 12'h0);
        look(20'h00101, 2'd0, 12'h0);

        phase = "R2 R3 R4 R5 R7 R12 mixed traffic";
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom % 100);
            s_lkv = ($urandom % 4) != 0;
            s_vpn = 20'h00400 + 20'($urandom % 24);
            s_acc = 2'($urandom % 4);
            s_off = 12'($urandom);
            s_fv = ($urandom % 3) == 0;
            s_fvpn = 20'h00400 + 20'($urandom % 24);
            s_fppn = 20'($urandom);
            s_fperm = 4'($urandom);
            s_iv = ($urandom % 10) == 0;
            s_ivpn = 20'h00400 + 20'($urandom % 24);
            if (r == 0) s_base = s_base + 32'h1000;
            step();
        end

        summary();
        $finish;
    end
endmodule